// File: doc/BRIEF.md
# Exposed-Datapath Internal Register Bank

This block holds the ten internal registers that the compiler names directly in a statically pipelined core. Decode hands it a set of independent register-write effects for the current cycle. These include two register-file read slots, an immediate slot, a high-part merge slot, two copy slots, a loop-start operation, and four result captures from the ALU, the FPU, the address adder and the load path. The bank applies every legal effect in parallel at the next clock edge. There is no forwarding: every effect sees the register values from the start of the cycle.

All ten registers are driven out as separate ports so the datapath and the branch-target selector can read them. The immediate register can be built up over two cycles. First a sign-extended long or short immediate is written. Then a high-part immediate is ORed into the top bits, which forms a full absolute constant. The loop-start register accepts only three things: the next PC, a restore from the load-value register, or no change. Its current value is always on its output port for a store. When two effects in one cycle claim the same register, the bank raises a flag in that cycle and leaves that register untouched. Every other effect in the cycle still lands.

Reset is asynchronous and active low. Its release is synchronised through a short flop chain, so the bank starts working a few edges after the reset pin rises.

Top module: `xreg_bank`

## Requirements
- R1: While reset is held, and until the first effect after it is released, all ten register outputs read zero and `illegal` is low when no effect is requested.
- R2: A register that no effect claims in a cycle keeps its value across the clock edge.
- R3: `alu_en`, `fpu_en`, `add_en` and `ld_en` each capture their own data input into OPER1, OPER2, ADDR and LV at the next edge, independently and in the same cycle if several are set.
- R4: Each register-file read slot writes its data into RS1 when its destination bit is 0 and into RS2 when it is 1. The two slots may fill RS1 and RS2 in the same cycle.
- R5: With `imm_en` set and `imm_long` low, SE receives the low 7 bits of `imm_val` sign-extended to the register width. Bits 16..7 of `imm_val` are ignored.
- R6: With `imm_en` set and `imm_long` high, SE receives all 17 bits of `imm_val` sign-extended to the register width.
- R7: With `hi_en` set, SE becomes its previous value ORed with `hi_val` placed in the top 17 bits of the word.
- R8: Each copy slot writes CP1 when its destination bit is 0 and CP2 when it is 1. The value copied is the register picked by the 4-bit source index: 0 SEQ, 1 RS1, 2 RS2, 3 SE, 4 CP1, 5 CP2, 6 OPER1, 7 OPER2, 8 ADDR, 9 LV. Indices 10 to 15 copy zero.
- R9: Every effect reads register values from the start of the cycle, including values that another effect overwrites at the same edge.
- R10: `seq_op` 1 loads SEQ with `pc`+1 modulo 2^W. `seq_op` 2 loads SEQ from LV. `seq_op` 0 leaves SEQ alone. `seq_op` 3 writes nothing and raises `illegal`.
- R11: When two effects in one cycle claim the same register, `illegal` is high in that cycle and that register keeps its old value. All unclaimed and singly claimed registers still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | W | Current program counter |
| rd0_en | input | 1 | Register-file read slot 0 enable |
| rd0_dst | input | 1 | Slot 0 destination: 0 RS1, 1 RS2 |
| rd0_data | input | W | Slot 0 read data |
| rd1_en | input | 1 | Register-file read slot 1 enable |
| rd1_dst | input | 1 | Slot 1 destination: 0 RS1, 1 RS2 |
| rd1_data | input | W | Slot 1 read data |
| imm_en | input | 1 | Immediate write into SE |
| imm_long | input | 1 | 1: 17-bit immediate, 0: 7-bit immediate |
| imm_val | input | 17 | Immediate field |
| hi_en | input | 1 | OR high-part immediate into SE |
| hi_val | input | 17 | High-part immediate |
| cp0_en | input | 1 | Copy slot 0 enable |
| cp0_dst | input | 1 | Copy slot 0 destination: 0 CP1, 1 CP2 |
| cp0_src | input | 4 | Copy slot 0 source index |
| cp1_en | input | 1 | Copy slot 1 enable |
| cp1_dst | input | 1 | Copy slot 1 destination: 0 CP1, 1 CP2 |
| cp1_src | input | 4 | Copy slot 1 source index |
| seq_op | input | 2 | Loop-start operation |
| alu_en | input | 1 | Capture ALU result |
| alu_data | input | W | ALU result |
| fpu_en | input | 1 | Capture FPU result |
| fpu_data | input | W | FPU result |
| add_en | input | 1 | Capture adder result |
| add_data | input | W | Adder result |
| ld_en | input | 1 | Capture load data |
| ld_data | input | W | Load data |
| seq_q | output | W | Loop-start register |
| rs1_q | output | W | Source register 1 |
| rs2_q | output | W | Source register 2 |
| se_q | output | W | Immediate register |
| cp1_q | output | W | Copy register 1 |
| cp2_q | output | W | Copy register 2 |
| oper1_q | output | W | ALU result register |
| oper2_q | output | W | FPU result register |
| addr_q | output | W | Adder result register |
| lv_q | output | W | Load-value register |
| illegal | output | 1 | Same-cycle write conflict or reserved loop-start code |

## Verification
The immediate paths are swept over every 7-bit short value, with junk in the unused upper field bits, and over a strided set of 17-bit long values. Together these separate correct sign extension from zero extension and from field truncation. The copy slots are tried with every pair of source indices, including copies of the copy registers themselves and the out-of-range indices. This shows start-of-cycle reads and zero fill. All 16 combinations of the two read slots are applied, along with same-cycle load-plus-restore and copy-from-LV patterns. These distinguish parallel start-of-cycle semantics from any forwarding, and legal dual writes from conflicts. A long pseudo-random run of mixed effects then checks every output against an arithmetic model, with particular attention to registers that are held versus written.

// File: rtl/xreg_pkg.sv
package xreg_pkg;

  localparam int NREG    = 10;
  localparam int IDX_W   = 4;
  localparam int LIMM_W  = 17;
  localparam int SIMM_W  = 7;
  localparam int NCLAIM  = 11;
  localparam int CNT_W   = $clog2(NCLAIM + 1);

  typedef enum logic [IDX_W-1:0] {
    IX_SEQ   = 4'd0,
    IX_RS1   = 4'd1,
    IX_RS2   = 4'd2,
    IX_SE    = 4'd3,
    IX_CP1   = 4'd4,
    IX_CP2   = 4'd5,
    IX_OPER1 = 4'd6,
    IX_OPER2 = 4'd7,
    IX_ADDR  = 4'd8,
    IX_LV    = 4'd9
  } xreg_ix_e;

  typedef enum logic [1:0] {
    SEQ_KEEP   = 2'd0,
    SEQ_PCNEXT = 2'd1,
    SEQ_FROMLV = 2'd2,
    SEQ_RSVD   = 2'd3
  } seq_op_e;

  // One-hot claim vector for one effect aimed at one register.
  function automatic logic [NREG-1:0] claim_bit(input logic en, input xreg_ix_e ix);
    logic [NREG-1:0] v;
    v = '0;
    if (en) v[ix] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/xreg_rst_sync.sv
module xreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];

endmodule

// File: rtl/xreg_imm.sv
module xreg_imm
  import xreg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              imm_long,
  input  logic [LIMM_W-1:0] imm_val,
  input  logic [LIMM_W-1:0] hi_val,
  input  logic [W-1:0]      se_cur,
  output logic [W-1:0]      lo_word,
  output logic [W-1:0]      hi_word
);

  localparam int LPAD = W - LIMM_W;
  localparam int SPAD = W - SIMM_W;

  logic [W-1:0] long_ext;
  logic [W-1:0] short_ext;

  always_comb begin
    long_ext  = {{LPAD{imm_val[LIMM_W-1]}}, imm_val};
    short_ext = {{SPAD{imm_val[SIMM_W-1]}}, imm_val[SIMM_W-1:0]};
    lo_word   = imm_long ? long_ext : short_ext;
    hi_word   = se_cur | {hi_val, {LPAD{1'b0}}};
  end

endmodule

// File: rtl/xreg_wsel.sv
module xreg_wsel
  import xreg_pkg::*;
(
  input  logic            rd0_en,
  input  logic            rd0_dst,
  input  logic            rd1_en,
  input  logic            rd1_dst,
  input  logic            cp0_en,
  input  logic            cp0_dst,
  input  logic            cp1_en,
  input  logic            cp1_dst,
  input  logic            imm_en,
  input  logic            hi_en,
  input  logic [1:0]      seq_op,
  input  logic            alu_en,
  input  logic            fpu_en,
  input  logic            add_en,
  input  logic            ld_en,
  output logic [NREG-1:0] we,
  output logic            illegal
);

  logic [NREG-1:0]  claim [NCLAIM];
  logic [CNT_W-1:0] cnt   [NREG];
  logic             seq_wr;
  logic             multi;

  assign seq_wr = (seq_op == SEQ_PCNEXT) || (seq_op == SEQ_FROMLV);

  assign claim[0]  = claim_bit(rd0_en, rd0_dst ? IX_RS2 : IX_RS1);
  assign claim[1]  = claim_bit(rd1_en, rd1_dst ? IX_RS2 : IX_RS1);
  assign claim[2]  = claim_bit(cp0_en, cp0_dst ? IX_CP2 : IX_CP1);
  assign claim[3]  = claim_bit(cp1_en, cp1_dst ? IX_CP2 : IX_CP1);
  assign claim[4]  = claim_bit(imm_en, IX_SE);
  assign claim[5]  = claim_bit(hi_en,  IX_SE);
  assign claim[6]  = claim_bit(seq_wr, IX_SEQ);
  assign claim[7]  = claim_bit(alu_en, IX_OPER1);
  assign claim[8]  = claim_bit(fpu_en, IX_OPER2);
  assign claim[9]  = claim_bit(add_en, IX_ADDR);
  assign claim[10] = claim_bit(ld_en,  IX_LV);

  // Count claims per register; exactly one claim grants the write.
  always_comb begin
    multi = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      cnt[r] = '0;
      for (int e = 0; e < NCLAIM; e++) begin
        cnt[r] = cnt[r] + CNT_W'(claim[e][r]);
      end
      we[r] = (cnt[r] == CNT_W'(1));
      if (cnt[r] > CNT_W'(1)) multi = 1'b1;
    end
  end

  assign illegal = multi || (seq_op == SEQ_RSVD);

endmodule

// File: rtl/xreg_bank.sv
module xreg_bank
  import xreg_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      pc,
  input  logic              rd0_en,
  input  logic              rd0_dst,
  input  logic [W-1:0]      rd0_data,
  input  logic              rd1_en,
  input  logic              rd1_dst,
  input  logic [W-1:0]      rd1_data,
  input  logic              imm_en,
  input  logic              imm_long,
  input  logic [LIMM_W-1:0] imm_val,
  input  logic              hi_en,
  input  logic [LIMM_W-1:0] hi_val,
  input  logic              cp0_en,
  input  logic              cp0_dst,
  input  logic [IDX_W-1:0]  cp0_src,
  input  logic              cp1_en,
  input  logic              cp1_dst,
  input  logic [IDX_W-1:0]  cp1_src,
  input  logic [1:0]        seq_op,
  input  logic              alu_en,
  input  logic [W-1:0]      alu_data,
  input  logic              fpu_en,
  input  logic [W-1:0]      fpu_data,
  input  logic              add_en,
  input  logic [W-1:0]      add_data,
  input  logic              ld_en,
  input  logic [W-1:0]      ld_data,
  output logic [W-1:0]      seq_q,
  output logic [W-1:0]      rs1_q,
  output logic [W-1:0]      rs2_q,
  output logic [W-1:0]      se_q,
  output logic [W-1:0]      cp1_q,
  output logic [W-1:0]      cp2_q,
  output logic [W-1:0]      oper1_q,
  output logic [W-1:0]      oper2_q,
  output logic [W-1:0]      addr_q,
  output logic [W-1:0]      lv_q,
  output logic              illegal
);

  localparam int NCOPY = 2;

  logic                   rst_sn;
  logic [NREG-1:0][W-1:0] regs_q;
  logic [NREG-1:0][W-1:0] regs_d;
  logic [NREG-1:0]        we;
  logic [W-1:0]           lo_word;
  logic [W-1:0]           hi_word;
  logic [IDX_W-1:0]       cp_src [NCOPY];
  logic [W-1:0]           cp_val [NCOPY];

  xreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  xreg_wsel u_wsel (
    .rd0_en  (rd0_en),
    .rd0_dst (rd0_dst),
    .rd1_en  (rd1_en),
    .rd1_dst (rd1_dst),
    .cp0_en  (cp0_en),
    .cp0_dst (cp0_dst),
    .cp1_en  (cp1_en),
    .cp1_dst (cp1_dst),
    .imm_en  (imm_en),
    .hi_en   (hi_en),
    .seq_op  (seq_op),
    .alu_en  (alu_en),
    .fpu_en  (fpu_en),
    .add_en  (add_en),
    .ld_en   (ld_en),
    .we      (we),
    .illegal (illegal)
  );

  xreg_imm #(.W(W)) u_imm (
    .imm_long (imm_long),
    .imm_val  (imm_val),
    .hi_val   (hi_val),
    .se_cur   (regs_q[IX_SE]),
    .lo_word  (lo_word),
    .hi_word  (hi_word)
  );

  assign cp_src[0] = cp0_src;
  assign cp_src[1] = cp1_src;

  // Copy source selection: start-of-cycle values, zero beyond the bank.
  for (genvar s = 0; s < NCOPY; s++) begin : g_copy
    always_comb begin
      cp_val[s] = '0;
      for (int r = 0; r < NREG; r++) begin
        if (cp_src[s] == IDX_W'(r)) cp_val[s] = regs_q[r];
      end
    end
  end

  // Next-state values; the write enables decide which are taken.
  always_comb begin
    regs_d            = regs_q;
    regs_d[IX_SEQ]    = (seq_op == SEQ_PCNEXT) ? (pc + {{(W-1){1'b0}}, 1'b1})
                                               : regs_q[IX_LV];
    regs_d[IX_RS1]    = (rd0_en && !rd0_dst) ? rd0_data : rd1_data;
    regs_d[IX_RS2]    = (rd0_en &&  rd0_dst) ? rd0_data : rd1_data;
    regs_d[IX_SE]     = imm_en ? lo_word : hi_word;
    regs_d[IX_CP1]    = (cp0_en && !cp0_dst) ? cp_val[0] : cp_val[1];
    regs_d[IX_CP2]    = (cp0_en &&  cp0_dst) ? cp_val[0] : cp_val[1];
    regs_d[IX_OPER1]  = alu_data;
    regs_d[IX_OPER2]  = fpu_data;
    regs_d[IX_ADDR]   = add_data;
    regs_d[IX_LV]     = ld_data;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      regs_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (we[r]) regs_q[r] <= regs_d[r];
      end
    end
  end

  assign seq_q   = regs_q[IX_SEQ];
  assign rs1_q   = regs_q[IX_RS1];
  assign rs2_q   = regs_q[IX_RS2];
  assign se_q    = regs_q[IX_SE];
  assign cp1_q   = regs_q[IX_CP1];
  assign cp2_q   = regs_q[IX_CP2];
  assign oper1_q = regs_q[IX_OPER1];
  assign oper2_q = regs_q[IX_OPER2];
  assign addr_q  = regs_q[IX_ADDR];
  assign lv_q    = regs_q[IX_LV];

endmodule

// File: rtl/xreg_bank_chk.sv
module xreg_bank_chk
  import xreg_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_sn,
  input logic [W-1:0]      pc,
  input logic              rd0_en,
  input logic              rd0_dst,
  input logic              rd1_en,
  input logic              rd1_dst,
  input logic              imm_en,
  input logic              hi_en,
  input logic [LIMM_W-1:0] hi_val,
  input logic [1:0]        seq_op,
  input logic              alu_en,
  input logic [W-1:0]      alu_data,
  input logic              ld_en,
  input logic [W-1:0]      seq_q,
  input logic [W-1:0]      rs1_q,
  input logic [W-1:0]      rs2_q,
  input logic [W-1:0]      se_q,
  input logic [W-1:0]      oper1_q,
  input logic [W-1:0]      lv_q,
  input logic              illegal
);

  assert_oper1_hold_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    !alu_en |=> oper1_q == $past(oper1_q));

  assert_oper1_load_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    alu_en |=> oper1_q == $past(alu_data));

  assert_se_merge_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (hi_en && !imm_en) |=>
      se_q == ($past(se_q) | ({{(W-LIMM_W){1'b0}}, $past(hi_val)} << (W-LIMM_W))));

  assert_seq_next_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (seq_op == 2'd1) |=> seq_q == $past(pc) + 1'b1);

  assert_seq_restore_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (seq_op == 2'd2 && ld_en) |=> seq_q == $past(lv_q));

  assert_rd_clash_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd0_en && rd1_en && rd0_dst == rd1_dst) |=>
      (rs1_q == $past(rs1_q)) && (rs2_q == $past(rs2_q)));

  assert_se_clash_flag_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    (imm_en && hi_en) |-> illegal);

  assert_se_clash_hold_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    (imm_en && hi_en) |=> se_q == $past(se_q));

endmodule

bind xreg_bank xreg_bank_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .pc       (pc),
  .rd0_en   (rd0_en),
  .rd0_dst  (rd0_dst),
  .rd1_en   (rd1_en),
  .rd1_dst  (rd1_dst),
  .imm_en   (imm_en),
  .hi_en    (hi_en),
  .hi_val   (hi_val),
  .seq_op   (seq_op),
  .alu_en   (alu_en),
  .alu_data (alu_data),
  .ld_en    (ld_en),
  .seq_q    (seq_q),
  .rs1_q    (rs1_q),
  .rs2_q    (rs2_q),
  .se_q     (se_q),
  .oper1_q  (oper1_q),
  .lv_q     (lv_q),
  .illegal  (illegal)
);

// File: tb/sim_xreg_bank.sv
module sim_xreg_bank;

  localparam int W          = 24;
  localparam int NR         = 10;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  pc;
  logic          rd0_en, rd0_dst, rd1_en, rd1_dst;
  logic [W-1:0]  rd0_data, rd1_data;
  logic          imm_en, imm_long, hi_en;
  logic [16:0]   imm_val, hi_val;
  logic          cp0_en, cp0_dst, cp1_en, cp1_dst;
  logic [3:0]    cp0_src, cp1_src;
  logic [1:0]    seq_op;
  logic          alu_en, fpu_en, add_en, ld_en;
  logic [W-1:0]  alu_data, fpu_data, add_data, ld_data;
  logic [W-1:0]  seq_q, rs1_q, rs2_q, se_q, cp1_q, cp2_q;
  logic [W-1:0]  oper1_q, oper2_q, addr_q, lv_q;
  logic          illegal;

  logic [W-1:0]  m [NR];
  int            n_vec;
  int            n_bad;
  logic [31:0]   rnd;

  xreg_bank #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pc(pc),
    .rd0_en(rd0_en), .rd0_dst(rd0_dst), .rd0_data(rd0_data),
    .rd1_en(rd1_en), .rd1_dst(rd1_dst), .rd1_data(rd1_data),
    .imm_en(imm_en), .imm_long(imm_long), .imm_val(imm_val),
    .hi_en(hi_en), .hi_val(hi_val),
    .cp0_en(cp0_en), .cp0_dst(cp0_dst), .cp0_src(cp0_src),
    .cp1_en(cp1_en), .cp1_dst(cp1_dst), .cp1_src(cp1_src),
    .seq_op(seq_op),
    .alu_en(alu_en), .alu_data(alu_data), .fpu_en(fpu_en), .fpu_data(fpu_data),
    .add_en(add_en), .add_data(add_data), .ld_en(ld_en), .ld_data(ld_data),
    .seq_q(seq_q), .rs1_q(rs1_q), .rs2_q(rs2_q), .se_q(se_q),
    .cp1_q(cp1_q), .cp2_q(cp2_q), .oper1_q(oper1_q), .oper2_q(oper2_q),
    .addr_q(addr_q), .lv_q(lv_q), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] next_rnd(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic clear_in();
    rd0_en = 0; rd0_dst = 0; rd0_data = '0;
    rd1_en = 0; rd1_dst = 0; rd1_data = '0;
    imm_en = 0; imm_long = 0; imm_val = '0; hi_en = 0; hi_val = '0;
    cp0_en = 0; cp0_dst = 0; cp0_src = '0;
    cp1_en = 0; cp1_dst = 0; cp1_src = '0;
    seq_op = 2'd0;
    alu_en = 0; fpu_en = 0; add_en = 0; ld_en = 0;
    alu_data = '0; fpu_data = '0; add_data = '0; ld_data = '0;
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] act [NR];
    act = '{seq_q, rs1_q, rs2_q, se_q, cp1_q, cp2_q, oper1_q, oper2_q, addr_q, lv_q};
    n_vec++;
    for (int i = 0; i < NR; i++) begin
      if (act[i] !== m[i]) begin
        n_bad++;
        $display("FAIL %s register %0d actual %h expected %h", tag, i, act[i], m[i]);
        break;
      end
    end
  endtask

  // Applies the inputs currently driven for one cycle and checks the result.
  task automatic step(input string tag);
    logic [W-1:0] nm [NR];
    int           c [NR];
    logic         exp_ill;
    logic [W-1:0] cv0, cv1, sx;
    #1;
    for (int i = 0; i < NR; i++) c[i] = 0;
    if (rd0_en) c[rd0_dst ? 2 : 1]++;
    if (rd1_en) c[rd1_dst ? 2 : 1]++;
    if (cp0_en) c[cp0_dst ? 5 : 4]++;
    if (cp1_en) c[cp1_dst ? 5 : 4]++;
    if (imm_en) c[3]++;
    if (hi_en)  c[3]++;
    if (seq_op == 2'd1 || seq_op == 2'd2) c[0]++;
    if (alu_en) c[6]++;
    if (fpu_en) c[7]++;
    if (add_en) c[8]++;
    if (ld_en)  c[9]++;
    exp_ill = (seq_op == 2'd3);
    for (int i = 0; i < NR; i++) if (c[i] > 1) exp_ill = 1'b1;
    n_vec++;
    if (illegal !== exp_ill) begin
      n_bad++;
      $display("FAIL %s illegal actual %b expected %b", tag, illegal, exp_ill);
    end
    cv0 = (int'(cp0_src) < NR) ? m[cp0_src] : '0;
    cv1 = (int'(cp1_src) < NR) ? m[cp1_src] : '0;
    if (imm_long) sx = W'(int'(imm_val) - (imm_val[16] ? 131072 : 0));
    else          sx = W'(int'(imm_val[6:0]) - (imm_val[6] ? 128 : 0));
    nm = m;
    if (c[0] == 1) nm[0] = (seq_op == 2'd1) ? pc + W'(1) : m[9];
    if (c[1] == 1) nm[1] = (rd0_en && !rd0_dst) ? rd0_data : rd1_data;
    if (c[2] == 1) nm[2] = (rd0_en &&  rd0_dst) ? rd0_data : rd1_data;
    if (c[3] == 1) nm[3] = imm_en ? sx : (m[3] | (W'(hi_val) << (W-17)));
    if (c[4] == 1) nm[4] = (cp0_en && !cp0_dst) ? cv0 : cv1;
    if (c[5] == 1) nm[5] = (cp0_en &&  cp0_dst) ? cv0 : cv1;
    if (c[6] == 1) nm[6] = alu_data;
    if (c[7] == 1) nm[7] = fpu_data;
    if (c[8] == 1) nm[8] = add_data;
    if (c[9] == 1) nm[9] = ld_data;
    @(posedge clk);
    m = nm;
    @(negedge clk);
    check_all(tag);
    clear_in();
  endtask

  task automatic fill_bank();
    rd0_en = 1; rd0_dst = 0; rd0_data = W'(24'h111111);
    rd1_en = 1; rd1_dst = 1; rd1_data = W'(24'h222222);
    imm_en = 1; imm_long = 1; imm_val = 17'h0AB33;
    seq_op = 2'd1; pc = W'(24'h0FFFFF);
    alu_en = 1; alu_data = W'(24'h666666);
    fpu_en = 1; fpu_data = W'(24'h777777);
    add_en = 1; add_data = W'(24'h888888);
    ld_en = 1;  ld_data  = W'(24'h999999);
    step("R4");
    cp0_en = 1; cp0_dst = 0; cp0_src = 4'd7;
    cp1_en = 1; cp1_dst = 1; cp1_src = 4'd8;
    step("R8");
  endtask

  initial begin
    #(CLK_PERIOD * WDOG);
    n_bad++;
    $display("FAIL watchdog expired actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0; rnd = 32'h1234_5678;
    pc = '0;
    clear_in();
    rst_n = 1'b0;
    for (int i = 0; i < NR; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");
    n_vec++;
    if (illegal !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 illegal actual %b expected 0", illegal);
    end

    // R3: every combination of the four result captures
    for (int k = 0; k < 16; k++) begin
      alu_en = k[0]; fpu_en = k[1]; add_en = k[2]; ld_en = k[3];
      alu_data = W'(32'h00A000 + k); fpu_data = W'(32'h00B000 + k);
      add_data = W'(32'h00C000 + k); ld_data  = W'(32'h00D000 + k);
      step("R3");
    end
    step("R2");

    // R4 and R11: all read-slot combinations
    for (int k = 0; k < 16; k++) begin
      rd0_en = k[0]; rd0_dst = k[1]; rd1_en = k[2]; rd1_dst = k[3];
      rd0_data = W'(32'h050500 + k); rd1_data = W'(32'h0A0A00 + k);
      step("R4");
    end

    // R5: every short immediate, with junk in the ignored upper bits
    for (int k = 0; k < 128; k++) begin
      imm_en = 1; imm_long = 0; imm_val = {10'b1011001110, k[6:0]};
      step("R5");
    end

    // R6: strided long immediates
    for (int k = 0; k < 512; k++) begin
      imm_en = 1; imm_long = 1; imm_val = 17'(k * 257);
      step("R6");
    end

    // R7: long low part then high-part OR
    for (int k = 0; k < 64; k++) begin
      imm_en = 1; imm_long = 1; imm_val = 17'(k * 1031);
      step("R6");
      hi_en = 1; hi_val = 17'(k * 2053 + 17'h10001);
      step("R7");
    end

    // R8: every pair of copy sources into distinct destinations
    fill_bank();
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        cp0_en = 1; cp0_dst = a[0]; cp0_src = 4'(a);
        cp1_en = 1; cp1_dst = ~a[0]; cp1_src = 4'(b);
        step("R8");
      end
    end

    // R9: load into LV while SEQ restores from it and a copy reads it
    fill_bank();
    ld_en = 1; ld_data = W'(24'h5A5A5A); seq_op = 2'd2;
    cp0_en = 1; cp0_dst = 0; cp0_src = 4'd9;
    cp1_en = 1; cp1_dst = 1; cp1_src = 4'd4;
    step("R9");
    imm_en = 1; imm_long = 0; imm_val = 17'h00040;
    cp0_en = 1; cp0_dst = 1; cp0_src = 4'd3;
    step("R9");

    // R10: loop-start operations, wrap and reserved code
    pc = {W{1'b1}}; seq_op = 2'd1; step("R10");
    pc = W'(24'h001234); seq_op = 2'd1; step("R10");
    seq_op = 2'd0; step("R10");
    ld_en = 1; ld_data = W'(24'hC0FFEE); step("R10");
    seq_op = 2'd2; step("R10");
    seq_op = 2'd3; pc = W'(24'h000777); alu_en = 1; alu_data = W'(24'h00BEEF);
    step("R10");

    // R11: clashing effects leave only the contested register alone
    imm_en = 1; imm_long = 1; imm_val = 17'h1FFFF; hi_en = 1; hi_val = 17'h00001;
    fpu_en = 1; fpu_data = W'(24'h314159);
    step("R11");
    cp0_en = 1; cp0_dst = 1; cp0_src = 4'd0; cp1_en = 1; cp1_dst = 1; cp1_src = 4'd6;
    add_en = 1; add_data = W'(24'h271828);
    step("R11");

    // R2: pseudo-random mixed effects against the model
    for (int k = 0; k < 4000; k++) begin
      rnd = next_rnd(rnd);
      rd0_en = rnd[0]; rd0_dst = rnd[1]; rd1_en = rnd[2]; rd1_dst = rnd[3];
      imm_en = rnd[4] & rnd[5]; imm_long = rnd[6]; hi_en = rnd[7] & rnd[8];
      cp0_en = rnd[9]; cp0_dst = rnd[10]; cp1_en = rnd[11]; cp1_dst = rnd[12];
      cp0_src = rnd[16:13]; cp1_src = rnd[20:17];
      seq_op = rnd[22:21];
      alu_en = rnd[23]; fpu_en = rnd[24]; add_en = rnd[25]; ld_en = rnd[26];
      imm_val = rnd[31:15]; hi_val = rnd[16:0];
      rnd = next_rnd(rnd);
      rd0_data = rnd[W-1:0]; alu_data = rnd[W+7:8]; pc = rnd[31:32-W];
      rnd = next_rnd(rnd);
      rd1_data = rnd[W-1:0]; fpu_data = rnd[W+7:8]; add_data = rnd[31:32-W];
      ld_data = rnd[W+3:4];
      step("R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule